// File: doc/BRIEF.md
# Nonvolatile Control Pin Decoder

This block sits behind the four active-low control pins of a static memory that carries a shadow nonvolatile array: chip select `ce_n`, output enable `oe_n`, write strobe `we_n` and nonvolatile select `nv_n`. All four pins and the supply-good flag are brought into the system clock domain through a synchroniser chain. The synchronised pin state is then classified into one of five modes: idle, array read, array write, save request or restore request.

Reads and writes become enables for the memory array. The read decode also drives the enable of the shared data bus. The save and restore modes produce one-cycle request pulses for an external copy engine. While that engine reports `busy`, the block issues nothing. A request fires only on the clock in which the synchronised pins move into the save or restore mode. A mode that is still held when the engine finishes therefore never starts a second operation.

Top module: `nvd_pin_decoder`

## Requirements
- R1: `rd_en` is high exactly when the synchronised pins show ce_n=0, oe_n=0, we_n=1, nv_n=1 and `busy` is low.
- R2: `wr_en` is high exactly when the synchronised pins show ce_n=0, we_n=0, nv_n=1 (any oe_n) and `busy` is low.
- R3: A `store_req` pulse is issued when the synchronised pins enter nv_n=0, ce_n=0, we_n=0, oe_n=1, provided `busy` is low and the synchronised supply flag is high.
- R4: A `recall_req` pulse is issued when the synchronised pins enter nv_n=0, ce_n=0, oe_n=0, we_n=1 and `busy` is low. The supply flag plays no part.
- R5: Each request is high for a single clock cycle per entry into its mode.
- R6: Staying in the save or restore mode never repeats a request, including across a busy period. Leaving the mode and entering it again is required.
- R7: Pulling we_n low while nv_n=0, ce_n=0 and oe_n=1 yields a save request and no restore request.
- R8: An entry into the save mode while the synchronised supply flag is low is discarded. Raising the flag later while the mode is still held issues nothing.
- R9: `dq_oe` follows `rd_en`. It is therefore low during any write, including a write with oe_n low.
- R10: While `busy` is high, `rd_en`, `wr_en`, `dq_oe` and both requests are low. In the cycle `busy` falls, a pending read or write condition appears on `rd_en`/`wr_en` at once.
- R11: After reset all outputs are low. Each pin passes through SYNC_STAGES flops before it is decoded. A request pulse becomes visible SYNC_STAGES+1 clock edges after a pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| we_n | input | 1 | Write strobe pin, active low, asynchronous |
| nv_n | input | 1 | Nonvolatile select pin, active low, asynchronous |
| supply_ok | input | 1 | Supply-good flag, high when a save may run |
| busy | input | 1 | Copy engine running, synchronous to clk |
| rd_en | output | 1 | Array read enable |
| wr_en | output | 1 | Array write enable |
| dq_oe | output | 1 | Data bus drive enable |
| store_req | output | 1 | One-cycle save request to the copy engine |
| recall_req | output | 1 | One-cycle restore request to the copy engine |

## Verification
The bench builds the decoder with SYNC_STAGES=2 and SUPPLY_SYNC=1. With these values the supply flag shares the pin latency, and a bench model of three clock edges predicts every request exactly. This brings within reach the hold-through-busy case, entry into save from the idle "nv_n low, oe_n high" state, and supply gating that is held while the flag changes. The same settings also expose the release of `busy` in the middle of a cycle for a pending read or write. Random pin streams that often hold their state then mix mode entries, exits and busy windows in orders that the directed cases do not list.

// File: rtl/nvd_pkg.sv
package nvd_pkg;

   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
      logic nv_n;
   } nvd_pins_t;

   typedef enum logic [2:0] {
      NVD_IDLE,
      NVD_READ,
      NVD_WRITE,
      NVD_SAVE,
      NVD_RESTORE
   } nvd_mode_e;

   function automatic nvd_mode_e nvd_classify(input nvd_pins_t p);
      nvd_mode_e m;
      m = NVD_IDLE;
      if (!p.ce_n) begin
         if (p.nv_n) begin
            if (!p.we_n)      m = NVD_WRITE;
            else if (!p.oe_n) m = NVD_READ;
         end else begin
            if (!p.we_n && p.oe_n)      m = NVD_SAVE;
            else if (p.we_n && !p.oe_n) m = NVD_RESTORE;
         end
      end
      return m;
   endfunction

endpackage

// File: rtl/nvd_sync.sv
module nvd_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_depth
      $error("nvd_sync needs at least two stages");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/nvd_mode_decode.sv
module nvd_mode_decode
   import nvd_pkg::*;
(
   input  nvd_pins_t pins,
   output logic      is_read,
   output logic      is_write,
   output logic      is_save,
   output logic      is_restore
);
   nvd_mode_e mode;

   always_comb begin
      mode       = nvd_classify(pins);
      is_read    = 1'b0;
      is_write   = 1'b0;
      is_save    = 1'b0;
      is_restore = 1'b0;
      case (mode)
         NVD_READ:    is_read    = 1'b1;
         NVD_WRITE:   is_write   = 1'b1;
         NVD_SAVE:    is_save    = 1'b1;
         NVD_RESTORE: is_restore = 1'b1;
         default:     ;
      endcase
   end
endmodule

// File: rtl/nvd_trigger.sv
module nvd_trigger (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   input  logic busy,
   input  logic gate,
   output logic req
);
   logic cond_q;
   logic req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         cond_q <= cond;
         req_q  <= cond && !cond_q && !busy && gate;
      end
   end

   assign req = req_q;

   // R5
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |=> !req_q);

   // R10
   req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> !$past(busy));

   // R6
   req_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> ($past(cond) && !$past(cond_q)));
endmodule

// File: rtl/nvd_pin_decoder.sv
module nvd_pin_decoder
   import nvd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit SUPPLY_SYNC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   input  logic nv_n,
   input  logic supply_ok,
   input  logic busy,
   output logic rd_en,
   output logic wr_en,
   output logic dq_oe,
   output logic store_req,
   output logic recall_req
);
   localparam int PIN_W = $bits(nvd_pins_t);

   nvd_pins_t pins_s;
   logic      supply_s;
   logic      is_read, is_write, is_save, is_restore;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("SYNC_STAGES must be at least 2");
   end

   if (SUPPLY_SYNC) begin : g_sup_sync
      logic [PIN_W:0] raw, syn;
      assign raw = {supply_ok, ce_n, oe_n, we_n, nv_n};
      nvd_sync #(.W(PIN_W+1), .STAGES(SYNC_STAGES),
                 .RST_VAL({1'b0, {PIN_W{1'b1}}})) u_sync (
         .clk(clk), .rst_n(rst_n), .d(raw), .q(syn));
      assign pins_s   = nvd_pins_t'(syn[PIN_W-1:0]);
      assign supply_s = syn[PIN_W];
   end else begin : g_sup_direct
      logic [PIN_W-1:0] raw, syn;
      assign raw = {ce_n, oe_n, we_n, nv_n};
      nvd_sync #(.W(PIN_W), .STAGES(SYNC_STAGES),
                 .RST_VAL({PIN_W{1'b1}})) u_sync (
         .clk(clk), .rst_n(rst_n), .d(raw), .q(syn));
      assign pins_s   = nvd_pins_t'(syn);
      assign supply_s = supply_ok;
   end

   nvd_mode_decode u_dec (
      .pins(pins_s), .is_read(is_read), .is_write(is_write),
      .is_save(is_save), .is_restore(is_restore));

   nvd_trigger u_save (
      .clk(clk), .rst_n(rst_n), .cond(is_save), .busy(busy),
      .gate(supply_s), .req(store_req));

   nvd_trigger u_restore (
      .clk(clk), .rst_n(rst_n), .cond(is_restore), .busy(busy),
      .gate(1'b1), .req(recall_req));

   assign rd_en = is_read  && !busy;
   assign wr_en = is_write && !busy;
   assign dq_oe = rd_en;

   // R9
   bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !dq_oe);

   // R8
   save_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |-> $past(supply_s));

   // R7
   req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |-> !recall_req);
endmodule

// File: tb/sim_nvd_pin_decoder.sv
module sim_nvd_pin_decoder;
   localparam int STAGES = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, nv_n = 1'b1;
   logic supply_ok = 1'b1, busy = 1'b0;
   logic rd_en, wr_en, dq_oe, store_req, recall_req;

   int checks = 0, fails = 0;
   int st_cnt = 0, rc_cnt = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   nvd_pin_decoder #(.SYNC_STAGES(STAGES), .SUPPLY_SYNC(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .nv_n(nv_n), .supply_ok(supply_ok), .busy(busy), .rd_en(rd_en),
      .wr_en(wr_en), .dq_oe(dq_oe), .store_req(store_req),
      .recall_req(recall_req));

   // reference model; s = {supply, ce, oe, we, nv}
   function automatic bit f_read(logic [4:0] s);
      return !s[3] && !s[2] && s[1] && s[0];
   endfunction
   function automatic bit f_write(logic [4:0] s);
      return !s[3] && !s[1] && s[0];
   endfunction
   function automatic bit f_save(logic [4:0] s);
      return !s[0] && !s[3] && !s[1] && s[2];
   endfunction
   function automatic bit f_restore(logic [4:0] s);
      return !s[0] && !s[3] && !s[2] && s[1];
   endfunction

   logic [4:0] m_stg [STAGES];
   logic m_sv_q, m_rs_q, m_sv_req, m_rs_req;
   logic [4:0] m_s;
   assign m_s = m_stg[STAGES-1];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) m_stg[i] <= 5'b01111;
         m_sv_q <= 0; m_rs_q <= 0; m_sv_req <= 0; m_rs_req <= 0;
      end else begin
         m_stg[0] <= {supply_ok, ce_n, oe_n, we_n, nv_n};
         for (int i = 1; i < STAGES; i++) m_stg[i] <= m_stg[i-1];
         m_sv_q   <= f_save(m_s);
         m_rs_q   <= f_restore(m_s);
         m_sv_req <= f_save(m_s) && !m_sv_q && !busy && m_s[4];
         m_rs_req <= f_restore(m_s) && !m_rs_q && !busy;
      end
   end

   task automatic check(string req, logic got, logic exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s at %0t: got %0b expected %0b", req, $time, got, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R1 rd_en",      rd_en,      f_read(m_s)  && !busy);
         check("R2 wr_en",      wr_en,      f_write(m_s) && !busy);
         check("R9 dq_oe",      dq_oe,      f_read(m_s)  && !busy);
         check("R3 store_req",  store_req,  m_sv_req);
         check("R4 recall_req", recall_req, m_rs_req);
         if (store_req)  st_cnt++;
         if (recall_req) rc_cnt++;
      end
   end

   task automatic pins(logic c, logic o, logic w, logic n);
      @(negedge clk); #2;
      ce_n = c; oe_n = o; we_n = w; nv_n = n;
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_int(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s at %0t: got %0d expected %0d", req, $time, got, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int s0, r0;
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 reset rd_en", rd_en, 0);
      check("R11 reset wr_en", wr_en, 0);
      check("R11 reset dq_oe", dq_oe, 0);
      check("R11 reset store_req", store_req, 0);
      check("R11 reset recall_req", recall_req, 0);

      // R11 latency and R5 pulse width
      pins(0, 1, 0, 0);
      @(posedge clk); @(posedge clk); @(negedge clk);
      check("R11 no early store_req", store_req, 0);
      @(negedge clk);
      check("R11 store_req at edge 3", store_req, 1);
      @(negedge clk);
      check("R5 store_req one cycle", store_req, 0);

      // R6 hold across busy
      @(negedge clk); #2 busy = 1'b1;
      cyc(6);
      #2 busy = 1'b0;
      s0 = st_cnt;
      cyc(8);
      check_int("R6 held save no retrigger", st_cnt, s0);
      pins(1, 1, 1, 1); cyc(4);
      s0 = st_cnt;
      pins(0, 1, 0, 0); cyc(6);
      check_int("R6 fresh entry saves", st_cnt, s0 + 1);

      // R7 we_n falls from idle nv state
      pins(1, 1, 1, 1); cyc(4);
      s0 = st_cnt; r0 = rc_cnt;
      pins(0, 1, 1, 0); cyc(5);
      check_int("R7 no-op state quiet", st_cnt + rc_cnt, s0 + r0);
      pins(0, 1, 0, 0); cyc(5);
      check_int("R7 store chosen", st_cnt, s0 + 1);
      check_int("R7 no recall", rc_cnt, r0);

      // R8 supply gating
      pins(1, 1, 1, 1);
      #1 supply_ok = 1'b0;
      cyc(4);
      s0 = st_cnt;
      pins(0, 1, 0, 0); cyc(6);
      check_int("R8 save blocked", st_cnt, s0);
      #2 supply_ok = 1'b1;
      cyc(6);
      check_int("R8 held save after supply rise", st_cnt, s0);
      pins(1, 1, 1, 1);
      #1 supply_ok = 1'b0;
      cyc(4);
      r0 = rc_cnt;
      pins(0, 0, 1, 0); cyc(6);
      check_int("R4 recall ignores supply", rc_cnt, r0 + 1);
      #2 supply_ok = 1'b1;

      // R9 write with oe_n low
      pins(0, 0, 0, 1); cyc(4);
      check("R9 write drives wr_en", wr_en, 1);
      check("R9 bus off in write", dq_oe, 0);

      // R10 busy masks, release takes effect at once
      @(negedge clk); #2 busy = 1'b1;
      pins(0, 0, 1, 1); cyc(4);
      check("R10 rd_en masked", rd_en, 0);
      check("R10 dq_oe masked", dq_oe, 0);
      @(negedge clk); #2 busy = 1'b0;
      #1;
      check("R10 rd_en at release", rd_en, 1);
      check("R10 dq_oe at release", dq_oe, 1);
      @(negedge clk); #2 busy = 1'b1;
      pins(0, 1, 0, 1); cyc(4);
      check("R10 wr_en masked", wr_en, 0);
      @(negedge clk); #2 busy = 1'b0;
      #1;
      check("R10 wr_en at release", wr_en, 1);

      // random phase
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk); #2;
         if ($urandom % 4 == 0) begin
            case ($urandom % 6)
               0: {ce_n, oe_n, we_n, nv_n} = 4'b1111;
               1: {ce_n, oe_n, we_n, nv_n} = 4'b0011;
               2: {ce_n, oe_n, we_n, nv_n} = {1'b0, 1'($urandom), 2'b01};
               3: {ce_n, oe_n, we_n, nv_n} = 4'b0100;
               4: {ce_n, oe_n, we_n, nv_n} = 4'b0010;
               default: {ce_n, oe_n, we_n, nv_n} = 4'($urandom);
            endcase
         end
         if ($urandom % 16 == 0) busy = ~busy;
         if ($urandom % 32 == 0) supply_ok = ~supply_ok;
      end
      cyc(2);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule